// File: doc/BRIEF.md
# SDRAM Single-Burst Command Sequencer

This block sits on the controller side of a synchronous DRAM and converts one host request into the command sequence for a single read or write burst. A request carries the direction, a bank, a row, a starting column and an auto-precharge flag. The block opens the row, waits the programmed row-to-column delay, issues the column command and tracks every data beat. It then closes the row, either by letting the memory precharge itself or by issuing a precharge command, and waits out the precharge time before it takes the next request.

The mode settings are inputs and are captured together with each request. These are the CAS latency, the burst length, full-page mode and single-location writes. A full-page burst gets its length from the request and is cut short with a burst-stop command. A single data-valid strobe tells the host in which cycles write data must be presented or read data arrives. Initialization, refresh and reordering across banks are handled elsewhere.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is high and after it is released with no request, the command pins show NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1), and `req_ack` and `data_valid` are low.
- R2: A request is accepted only in the idle state. Acceptance raises `req_ack` for exactly one cycle, in the same cycle as ACTIVE (0,0,1,1), with the row on the address pins and the bank on the bank pins.
- R3: READ (0,1,0,1) or WRITE (0,1,0,0) appears exactly T_RCD cycles after ACTIVE, with NOPs in between. It carries the same bank, the column on address bits 7..0, the effective auto-precharge flag on address bit 10, and zeros on the other address bits.
- R4: Only the six encodings NOP, ACTIVE, READ, WRITE, PRECHARGE (0,0,1,0) and BURST STOP (0,1,1,0) are driven.
- R5: Outside full-page mode, burst-length code 0/1/2/3 gives 1/2/4/8 beats.
- R6: For a write, `data_valid` is high in the WRITE cycle and in the following beats-1 cycles, and low otherwise.
- R7: For a read, `data_valid` is high for beats consecutive cycles starting 2 cycles after READ (latency select 0) or 3 cycles after READ (latency select 1).
- R8: With single-location writes selected, a write has exactly one beat and is never full-page, while reads keep the programmed length.
- R9: In full-page mode a burst has `req_fp_len`+1 beats. BURST STOP is issued exactly that many cycles after the column command, and the auto-precharge request is ignored (address bit 10 = 0).
- R10: Without effective auto precharge, PRECHARGE is issued to the burst's bank with address bit 10 low. It comes in the cycle after the last beat, or for a full-page write in the cycle after BURST STOP.
- R11: With effective auto precharge, no PRECHARGE command is issued.
- R12: A request held during a burst is not acknowledged until recovery ends. Its ACTIVE appears T_RP+1 cycles after the closing point, which is the PRECHARGE cycle or, under auto precharge, the cycle after the last beat. Mode inputs that change after acceptance do not affect the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BANK_W | Bank to access |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Request self-timed precharge at burst end |
| req_fp_len | input | COL_W | Full-page beats minus one |
| cfg_cl3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| cfg_blen | input | 2 | Burst length code: 1, 2, 4 or 8 beats |
| cfg_fullpage | input | 1 | Full-page burst mode |
| cfg_wr_single | input | 1 | Writes access one location |
| req_ack | output | 1 | One-cycle acceptance pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| data_valid | output | 1 | Data beat strobe to the host |

## Verification
The hardest case to reach is a request that waits while the sequencer is still busy: it must be taken at the first idle cycle, at an exact distance from the closing point. The mode inputs also change underneath it while the previous burst is in flight. The bench raises the second request in the cycle right after the first is acknowledged, with new fields and new mode settings. It then checks the gap between the two ACTIVE commands and the beat pattern of both bursts. A full-page write reaches the case where the last beat and the stop condition fall in the same cycle, which forces the delayed PRECHARGE. A full-page read of 256 beats exercises the widest counter range.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_RD   = 4'b0101,
    CMD_WR   = 4'b0100,
    CMD_PRE  = 4'b0010,
    CMD_STOP = 4'b0110
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_XFER,
    ST_CLOSE,
    ST_RECOVER
  } seq_state_e;

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/seq_beats.sv
module seq_beats #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] nbeats,
  output logic          dv,
  output logic          at_term,
  output logic          at_last
);
  logic [CW-1:0] cnt, lead_q, n_q;
  logic          run;

  assign at_term = run && (cnt == n_q - CW'(1));
  assign at_last = run && (cnt == lead_q + n_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      lead_q <= '0;
      n_q    <= '0;
      dv     <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      cnt    <= '0;
      lead_q <= lead;
      n_q    <= nbeats;
      dv     <= (lead == '0);
    end else begin
      if (run)     cnt <= cnt + CW'(1);
      if (at_last) run <= 1'b0;
      dv <= run && !at_last && ((cnt + CW'(1)) >= lead_q);
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  input  logic [COL_W-1:0]  req_fp_len,
  input  logic              cfg_cl3,
  input  logic [1:0]        cfg_blen,
  input  logic              cfg_fullpage,
  input  logic              cfg_wr_single,
  output logic              req_ack,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              data_valid
);
  localparam int CNT_W   = COL_W + 2;
  localparam int DLY_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  seq_state_e        st, st_n;
  sd_cmd_e           cmd_q, cmd_n;
  logic [ROW_W-1:0]  addr_q, addr_n;
  logic [BANK_W-1:0] ba_q, ba_n;
  logic              ack_q, ack_n;

  // request captured at acceptance
  logic              wr_q, ap_q, fp_q, term_sent;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [CNT_W-1:0]  nb_q, lead_q;

  // decode of the incoming request against the mode inputs
  logic              single_in, fp_in, ap_in;
  logic [CNT_W-1:0]  nb_in, lead_in;

  logic take, dly_load, dly_zero, trk_start, trk_term, trk_last, term_set;
  logic [DLY_W-1:0] dly_val;

  always_comb begin
    single_in = req_write && cfg_wr_single;
    fp_in     = cfg_fullpage && !single_in;
    ap_in     = req_autopre && !fp_in;
    if (single_in)  nb_in = CNT_W'(1);
    else if (fp_in) nb_in = CNT_W'(req_fp_len) + CNT_W'(1);
    else            nb_in = CNT_W'(1) << cfg_blen;
    lead_in = req_write ? '0 : (cfg_cl3 ? CNT_W'(3) : CNT_W'(2));
  end

  always_comb begin
    st_n      = st;
    cmd_n     = CMD_NOP;
    addr_n    = '0;
    ba_n      = '0;
    ack_n     = 1'b0;
    take      = 1'b0;
    dly_load  = 1'b0;
    dly_val   = '0;
    trk_start = 1'b0;
    term_set  = 1'b0;
    case (st)
      ST_IDLE: if (req_valid) begin
        take     = 1'b1;
        ack_n    = 1'b1;
        cmd_n    = CMD_ACT;
        addr_n   = req_row;
        ba_n     = req_bank;
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_RCD - 1);
        st_n     = ST_OPEN;
      end
      ST_OPEN: if (dly_zero) begin
        cmd_n          = wr_q ? CMD_WR : CMD_RD;
        addr_n         = ROW_W'(col_q);
        addr_n[AP_BIT] = ap_q;
        ba_n           = bank_q;
        trk_start      = 1'b1;
        st_n           = ST_XFER;
      end
      ST_XFER: begin
        if (fp_q && trk_term && !term_sent) begin
          cmd_n    = CMD_STOP;
          term_set = 1'b1;
        end
        if (trk_last) begin
          if (fp_q && trk_term && !term_sent) begin
            st_n = ST_CLOSE;
          end else begin
            if (!ap_q) begin
              cmd_n = CMD_PRE;
              ba_n  = bank_q;
            end
            dly_load = 1'b1;
            dly_val  = DLY_W'(T_RP - 1);
            st_n     = ST_RECOVER;
          end
        end
      end
      ST_CLOSE: begin
        cmd_n    = CMD_PRE;
        ba_n     = bank_q;
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_RP - 1);
        st_n     = ST_RECOVER;
      end
      ST_RECOVER: if (dly_zero) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      ba_q      <= '0;
      ack_q     <= 1'b0;
      wr_q      <= 1'b0;
      ap_q      <= 1'b0;
      fp_q      <= 1'b0;
      bank_q    <= '0;
      col_q     <= '0;
      nb_q      <= '0;
      lead_q    <= '0;
      term_sent <= 1'b0;
    end else begin
      st     <= st_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      ba_q   <= ba_n;
      ack_q  <= ack_n;
      if (take) begin
        wr_q   <= req_write;
        ap_q   <= ap_in;
        fp_q   <= fp_in;
        bank_q <= req_bank;
        col_q  <= req_col;
        nb_q   <= nb_in;
        lead_q <= lead_in;
      end
      if (trk_start)     term_sent <= 1'b0;
      else if (term_set) term_sent <= 1'b1;
    end
  end

  seq_delay #(.W(DLY_W)) u_delay (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
  );

  seq_beats #(.CW(CNT_W)) u_beats (
    .clk(clk), .rst(rst), .start(trk_start), .lead(lead_q), .nbeats(nb_q),
    .dv(data_valid), .at_term(trk_term), .at_last(trk_last)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba   = ba_q;
  assign req_ack = ack_q;
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int T_RCD = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ack,
  input logic [3:0] cmd,
  input logic       data_valid
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  p_ack_active_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (cmd == 4'b0011));

  p_write_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0100) |-> data_valid);

  p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0101) |-> !data_valid);

  p_pre_after_data_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> !data_valid);

  p_legal_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0111) || (cmd == 4'b0011) || (cmd == 4'b0101) ||
    (cmd == 4'b0100) || (cmd == 4'b0010) || (cmd == 4'b0110));

  generate
    if (T_RCD >= 2) begin : g_rcd
      p_rcd_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011) |=> (cmd == 4'b0111));
    end
  endgenerate
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst(rst), .req_ack(req_ack),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), .data_valid(data_valid)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0, cfg_blen = '0;
  logic [11:0] req_row = '0;
  logic [7:0] req_col = '0, req_fp_len = '0;
  logic cfg_cl3 = 1'b0, cfg_fullpage = 1'b0, cfg_wr_single = 1'b0;
  logic req_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, data_valid;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  always #2.5 clk = ~clk;

  sdram_burst_seq #(.T_RCD(T_RCD), .T_RP(T_RP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_fp_len(req_fp_len), .cfg_cl3(cfg_cl3),
    .cfg_blen(cfg_blen), .cfg_fullpage(cfg_fullpage), .cfg_wr_single(cfg_wr_single),
    .req_ack(req_ack), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .data_valid(data_valid)
  );

  typedef struct {
    int          rel;
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic [1:0]  ba;
    int          gap;
    string       tag;
  } cmd_exp_t;

  typedef struct {
    int    rel;
    string tag;
  } dv_exp_t;

  cmd_exp_t cq[$];
  dv_exp_t  dq[$];
  int cyc = 0, base = 0, n_chk = 0, n_err = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares observed commands and beats against the scoreboard
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      logic [3:0] c;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (c != 4'b0111) begin
        if (cq.size() == 0) begin
          chk(1'b0, "R11/R12", "unexpected command", c, 4'b0111);
        end else begin
          cmd_exp_t e;
          e = cq.pop_front();
          if (c == 4'b0011) begin
            if (e.gap != 0) chk(cyc - base == e.gap, "R12", "ACTIVE gap", cyc - base, e.gap);
            base = cyc;
          end
          chk(c == e.cmd, e.tag, "command", c, e.cmd);
          chk(cyc - base == e.rel, e.tag, "command cycle", cyc - base, e.rel);
          chk(sd_addr == e.addr, e.tag, "address", sd_addr, e.addr);
          chk(sd_ba == e.ba, e.tag, "bank", sd_ba, e.ba);
        end
      end
      if (data_valid) begin
        if (dq.size() == 0) begin
          chk(1'b0, "R6/R7", "unexpected data beat", cyc - base, -1);
        end else begin
          dv_exp_t d;
          d = dq.pop_front();
          chk(cyc - base == d.rel, d.tag, "beat cycle", cyc - base, d.rel);
        end
      end
    end
  end

  task automatic send(input bit wr, input logic [1:0] bk, input logic [11:0] row,
                      input logic [7:0] col, input bit ap, input bit cl3,
                      input logic [1:0] bl, input bit fp, input logic [7:0] fl,
                      input bit single, input int gap, input string tg,
                      output int close_rel);
    bit sw, fpe, ape;
    int n, lead, last, pre;
    cmd_exp_t e;
    dv_exp_t d;
    sw   = wr && single;
    fpe  = fp && !sw;
    n    = sw ? 1 : (fpe ? int'(fl) + 1 : (1 << bl));
    ape  = ap && !fpe;
    lead = wr ? 0 : (cl3 ? 3 : 2);
    e = '{0, 4'b0011, row, bk, gap, {"R2/R4 ", tg}};
    cq.push_back(e);
    e = '{T_RCD, wr ? 4'b0100 : 4'b0101, (12'(ape) << 10) | 12'(col), bk, 0, {"R3/R4 ", tg}};
    cq.push_back(e);
    for (int i = 0; i < n; i++) begin
      d = '{T_RCD + lead + i, {wr ? "R6 " : "R7 ", tg}};
      dq.push_back(d);
    end
    if (fpe) begin
      e = '{T_RCD + n, 4'b0110, 12'h000, 2'b00, 0, "R9"};
      cq.push_back(e);
    end
    last = T_RCD + lead + n - 1;
    if (!ape) begin
      pre = (fpe && wr) ? T_RCD + n + 1 : last + 1;
      e = '{pre, 4'b0010, 12'h000, bk, 0, "R10"};
      cq.push_back(e);
      close_rel = pre;
    end else begin
      close_rel = last + 1;
    end
    req_write = wr; req_bank = bk; req_row = row; req_col = col;
    req_autopre = ap; req_fp_len = fl; cfg_cl3 = cl3; cfg_blen = bl;
    cfg_fullpage = fp; cfg_wr_single = single;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (cq.size() != 0 || dq.size() != 0) @(negedge clk);
    repeat (T_RP + 6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cl;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(req_ack == 1'b0, "R1", "reset ack", req_ack, 0);
    chk(data_valid == 1'b0, "R1", "reset data_valid", data_valid, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "idle command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    mon_on = 1'b1;

    // R5/R6/R10: write, 4 beats, explicit precharge
    send(1, 2'd2, 12'hABC, 8'h12, 0, 0, 2'd2, 0, 8'd0, 0, 0, "R5", cl); drain();
    // R7/R11: read, 8 beats, latency 2, auto precharge
    send(0, 2'd1, 12'h123, 8'hF8, 1, 0, 2'd3, 0, 8'd0, 0, 0, "R5/R11", cl); drain();
    // R7: read, 2 beats, latency 3, explicit precharge
    send(0, 2'd3, 12'hFFF, 8'h01, 0, 1, 2'd1, 0, 8'd0, 0, 0, "R5", cl); drain();
    // R5/R11: write, single beat, auto precharge
    send(1, 2'd0, 12'h001, 8'hFF, 1, 0, 2'd0, 0, 8'd0, 0, 0, "R5/R11", cl); drain();
    // R8: single-location write with 8-beat mode and full page set
    send(1, 2'd1, 12'h055, 8'h40, 0, 0, 2'd3, 1, 8'd7, 1, 0, "R8", cl); drain();
    // R8: read under single-location write mode keeps 4 beats
    send(0, 2'd2, 12'h0AA, 8'h04, 0, 1, 2'd2, 0, 8'd0, 1, 0, "R8", cl); drain();
    // R9: full-page write, 6 beats, auto precharge request ignored
    send(1, 2'd3, 12'h777, 8'h30, 1, 0, 2'd0, 1, 8'd5, 0, 0, "R9", cl); drain();
    // R9: full-page read, latency 3, 10 beats
    send(0, 2'd0, 12'h800, 8'hFE, 0, 1, 2'd1, 1, 8'd9, 0, 0, "R9", cl); drain();
    // R9: full-page read of the whole row
    send(0, 2'd2, 12'h3C3, 8'h00, 0, 0, 2'd0, 1, 8'd255, 0, 0, "R9", cl); drain();

    // R12: request held while busy, auto-precharge closing point
    send(0, 2'd1, 12'h111, 8'h20, 1, 0, 2'd2, 0, 8'd0, 0, 0, "R12", cl);
    send(1, 2'd2, 12'h222, 8'h33, 0, 1, 2'd1, 0, 8'd0, 0, cl + T_RP + 1, "R12", cl);
    // R12: request held while busy, PRECHARGE closing point
    send(0, 2'd3, 12'h333, 8'h44, 1, 1, 2'd3, 0, 8'd0, 0, cl + T_RP + 1, "R12", cl);
    drain();
    send(1, 2'd0, 12'h444, 8'h55, 0, 0, 2'd1, 0, 8'd0, 0, 0, "R12", cl);
    send(0, 2'd1, 12'h555, 8'h66, 0, 0, 2'd0, 1, 8'd3, 0, cl + T_RP + 1, "R12", cl);
    drain();

    chk(cq.size() == 0 && dq.size() == 0, "R12", "scoreboard empty",
        cq.size() + dq.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule